// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit side of an I2C bus master. Software starts a transfer with a command, and the block then drives a Start condition. Software then hands over bytes one at a time through a data write. The block shifts each byte out on SDA, most significant bit first, and samples the receiver's acknowledge on the ninth clock. Between bytes the block keeps SCL low until software completes a handshake. The handshake is a read of the first status register followed by a data write. A Stop request that software issues during the last byte makes the block finish with a Stop condition and return to slave mode.

Both lines are modelled as open-drain. The block only pulls a line low (`scl_pull`, `sda_pull`) and observes the resolved level on `scl_in` and `sda_in`. A fixed prescaler sets the SCL half period.

The block reports status through a set of flags:
- a start-sent flag
- a byte-done flag
- an acknowledge-failure flag
- a bus-error flag
- an arbitration-lost flag
- an event summary
- a bus-busy flag

Status flags clear as side effects of status reads. A Start or Stop condition that appears on the first clock of a 9-bit slot does not raise a bus error. Instead it clears the busy flag, and the transfer continues.

Top module: `i2cm_tx_ctrl`

## Requirements
- R1: After synchronous reset the block is in slave mode (`master`=0). All flags, `busy` and `irq` are 0, and neither line is pulled.
- R2: A command write with `cmd_start`=1 while idle drives SDA low while SCL is high. It then pulls SCL low and sets `start_sent`, `busy` and `master`.
- R3: While `start_sent` or `byte_done` is set, SCL stays pulled low. A transfer starts only on a `data_we` that comes in a later cycle than a `stat1_rd`. A `data_we` with no earlier `stat1_rd` leaves SCL low and the flags unchanged.
- R4: Each byte goes out most significant bit first, one bit per SCL pulse. SDA is stable while SCL is high, and SDA is released on the ninth pulse.
- R5: An acknowledge sampled low at the rise of the ninth clock sets `byte_done`, and SCL is then held low.
- R6: A `cmd_stop` written during a byte makes the block produce a Stop condition after an acknowledged ninth clock, without setting `byte_done`. The block then clears `master`, and `busy` reads 0.
- R7: An acknowledge sampled high sets `ack_fail`. Both lines are then released, and the block stays master until a Start or Stop command.
- R8: A `stat2_rd` clears `ack_fail`. If the read falls while SCL is still high on the ninth clock of a failed byte, `ack_fail` is set again one cycle later.
- R9: A data bit of 1 that is sampled low at the rise of SCL sets `arb_lost`, clears `master` and releases both lines in the next cycle.
- R10: A Start or Stop condition seen during any bit of a byte other than the first sets `bus_err`. It also releases both lines.
- R11: A Start or Stop condition seen during the first bit of a byte sets no `bus_err` and clears `busy`. The byte still completes.
- R12: `ev_any` is the OR of the five flags. `irq` equals `ev_any` when the `cmd_irq_en` value from the last command write is 1, and is 0 otherwise.
- R13: A `stat2_rd` clears `bus_err` and `arb_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_start | input | 1 | Start request, valid with cmd_we |
| cmd_stop | input | 1 | Stop request, valid with cmd_we |
| cmd_irq_en | input | 1 | Interrupt enable, latched on cmd_we |
| stat1_rd | input | 1 | Read strobe of status register 1 |
| stat2_rd | input | 1 | Read strobe of status register 2 |
| data_we | input | 1 | Data register write strobe |
| data_in | input | 8 | Byte to transmit |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| start_sent | output | 1 | Start condition sent, waiting for a byte |
| byte_done | output | 1 | Byte acknowledged, waiting for the next one |
| ack_fail | output | 1 | Acknowledge failure |
| bus_err | output | 1 | Misplaced Start or Stop seen |
| arb_lost | output | 1 | Arbitration lost |
| ev_any | output | 1 | OR of all flags |
| busy | output | 1 | Bus busy between Start and Stop |
| master | output | 1 | Master mode |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit index or shift register shows up as a wrong byte on SDA. It is visible at the rising edges of SCL within the same byte. A wrong or missing handshake latch shows up as SCL released early or never, which is visible one prescaler half period after the data write. Flag errors in the acknowledge, arbitration and bus-error paths show on the flag outputs one cycle after the causing bus sample. The re-set of the acknowledge failure, and the first-pulse exemption for misplaced conditions, are checked cycle by cycle inside the ninth and first clock pulses. All 256 byte values go out in one transfer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STA_A,
        S_STA_B,
        S_WAIT,
        S_LO,
        S_HI,
        S_REL,
        S_STP_A,
        S_STP_B,
        S_STP_C
    } i2cm_state_e;

    typedef struct packed {
        logic start_sent;
        logic byte_done;
        logic ack_fail;
        logic bus_err;
        logic arb_lost;
    } i2cm_flags_t;

    function automatic logic any_event(i2cm_flags_t f);
        return |f;
    endfunction

    function automatic logic in_byte(i2cm_state_e s);
        return (s == S_LO) || (s == S_HI);
    endfunction

endpackage

// File: rtl/i2cm_shifter.sv
module i2cm_shifter #(
    parameter int W = 8,
    localparam int IW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  din,
    input  logic          shift,
    output logic          msb,
    output logic [IW-1:0] idx
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= din;
            idx <= '0;
        end else if (shift) begin
            sr  <= {sr[W-2:0], 1'b0};
            idx <= idx + IW'(1);
        end
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic first_pulse,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_det || stop_det) begin
                busy <= first_pulse ? 1'b0 : start_det;
            end
        end
    end

    assign start_det = scl_q && scl_in && sda_q && !sda_in;
    assign stop_det  = scl_q && scl_in && !sda_q && sda_in;

    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !busy); // R6
endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags import i2cm_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  i2cm_flags_t set_f,
    input  logic        clr_xfer,
    input  logic        clr_err,
    output i2cm_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.start_sent <= set_f.start_sent | (q.start_sent & ~clr_xfer);
            q.byte_done  <= set_f.byte_done  | (q.byte_done  & ~clr_xfer);
            q.ack_fail   <= ~clr_err & (q.ack_fail | set_f.ack_fail);
            q.bus_err    <= ~clr_err & (q.bus_err  | set_f.bus_err);
            q.arb_lost   <= ~clr_err & (q.arb_lost | set_f.arb_lost);
        end
    end
endmodule

// File: rtl/i2cm_tx_ctrl.sv
module i2cm_tx_ctrl import i2cm_pkg::*; #(
    parameter int HALF_CYC = 4,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_irq_en,
    input  logic              stat1_rd,
    input  logic              stat2_rd,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              start_sent,
    output logic              byte_done,
    output logic              ack_fail,
    output logic              bus_err,
    output logic              arb_lost,
    output logic              ev_any,
    output logic              busy,
    output logic              master,
    output logic              irq
);
    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int IW = $clog2(BYTE_W + 1);

    i2cm_state_e st, st_n;
    logic [PW-1:0] ph;
    logic          ph_last;
    logic          ack_q, armed, stop_pend, ite_q;
    i2cm_flags_t   flg, set_f;
    logic          clr_xfer, ld, adv, cur_bit;
    logic [IW-1:0] idx;
    logic          data_slot, first_pulse, start_det, stop_det, cond;
    logic          ack_now, scl_drv, sda_drv, start_cmd, stop_cmd;

    assign start_cmd   = cmd_we && cmd_start;
    assign stop_cmd    = cmd_we && cmd_stop;
    assign ph_last     = (ph == PW'(HALF_CYC - 1));
    assign data_slot   = (idx < IW'(BYTE_W));
    assign first_pulse = in_byte(st) && (idx == '0);
    assign cond        = start_det || stop_det;
    assign ack_now     = (ph == '0) ? sda_in : ack_q;

    i2cm_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .load(ld), .din(data_in),
        .shift(adv), .msb(cur_bit), .idx(idx)
    );

    i2cm_busmon u_mon (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .first_pulse(first_pulse), .start_det(start_det),
        .stop_det(stop_det), .busy(busy)
    );

    i2cm_flags u_flags (
        .clk(clk), .rst(rst), .set_f(set_f), .clr_xfer(clr_xfer),
        .clr_err(stat2_rd), .q(flg)
    );

    always_comb begin
        st_n     = st;
        scl_drv  = 1'b0;
        sda_drv  = 1'b0;
        set_f    = '0;
        clr_xfer = 1'b0;
        ld       = 1'b0;
        adv      = 1'b0;
        case (st)
            S_IDLE: begin
                if (start_cmd) st_n = S_STA_A;
            end
            S_STA_A: begin
                sda_drv = 1'b1;
                if (ph_last) st_n = S_STA_B;
            end
            S_STA_B: begin
                sda_drv = 1'b1;
                scl_drv = 1'b1;
                if (ph_last) begin
                    st_n             = S_WAIT;
                    set_f.start_sent = 1'b1;
                end
            end
            S_WAIT: begin
                scl_drv = 1'b1;
                if (stop_cmd) begin
                    st_n     = S_STP_A;
                    clr_xfer = 1'b1;
                end else if (data_we && armed) begin
                    st_n     = S_LO;
                    clr_xfer = 1'b1;
                    ld       = 1'b1;
                end
            end
            S_LO: begin
                scl_drv = 1'b1;
                sda_drv = data_slot && !cur_bit;
                if (cond && !first_pulse) begin
                    set_f.bus_err = 1'b1;
                    st_n          = S_REL;
                end else if (ph_last) begin
                    st_n = S_HI;
                end
            end
            S_HI: begin
                sda_drv = data_slot && !cur_bit;
                if (cond && !first_pulse) begin
                    set_f.bus_err = 1'b1;
                    st_n          = S_REL;
                end else if (data_slot && ph == '0 && cur_bit && !sda_in) begin
                    set_f.arb_lost = 1'b1;
                    st_n           = S_IDLE;
                end else begin
                    if (!data_slot && ack_now) set_f.ack_fail = 1'b1;
                    if (ph_last) begin
                        if (data_slot) begin
                            adv  = 1'b1;
                            st_n = S_LO;
                        end else if (ack_now) begin
                            st_n = S_REL;
                        end else if (stop_pend) begin
                            st_n = S_STP_A;
                        end else begin
                            set_f.byte_done = 1'b1;
                            st_n            = S_WAIT;
                        end
                    end
                end
            end
            S_REL: begin
                if (start_cmd)     st_n = S_STA_A;
                else if (stop_cmd) st_n = S_STP_A;
            end
            S_STP_A: begin
                scl_drv = 1'b1;
                sda_drv = 1'b1;
                if (ph_last) st_n = S_STP_B;
            end
            S_STP_B: begin
                sda_drv = 1'b1;
                if (ph_last) st_n = S_STP_C;
            end
            S_STP_C: begin
                st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            ph        <= '0;
            ack_q     <= 1'b0;
            armed     <= 1'b0;
            stop_pend <= 1'b0;
            ite_q     <= 1'b0;
        end else begin
            st <= st_n;
            ph <= (st_n != st || ph_last) ? '0 : ph + PW'(1);
            if (st == S_HI && ph == '0 && !data_slot) ack_q <= sda_in;
            armed     <= (st == S_WAIT) && (st_n == S_WAIT) &&
                         (armed || (stat1_rd && (flg.start_sent || flg.byte_done)));
            stop_pend <= in_byte(st_n) && (stop_pend || stop_cmd);
            if (cmd_we) ite_q <= cmd_irq_en;
        end
    end

    assign scl_pull   = scl_drv;
    assign sda_pull   = sda_drv;
    assign start_sent = flg.start_sent;
    assign byte_done  = flg.byte_done;
    assign ack_fail   = flg.ack_fail;
    assign bus_err    = flg.bus_err;
    assign arb_lost   = flg.arb_lost;
    assign ev_any     = any_event(flg);
    assign master     = (st != S_IDLE);
    assign irq        = ite_q && any_event(flg);

    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        (flg.start_sent || flg.byte_done) |-> scl_drv); // R3
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == S_HI && $past(st) == S_HI) |-> $stable(sda_drv)); // R4
    AST_NACK_FREES_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.ack_fail) |-> !scl_drv); // R7
    AST_ARB_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.arb_lost) |-> !master); // R9
    AST_FIRST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(flg.bus_err) |-> ($past(idx) != '0)); // R11
endmodule

// File: tb/i2cm_tx_ctrl_test.sv
module i2cm_tx_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic cmd_we = 0, cmd_start = 0, cmd_stop = 0, cmd_irq_en = 0;
    logic stat1_rd = 0, stat2_rd = 0, data_we = 0;
    logic [7:0] data_in = '0;
    logic ext_sda_low = 1'b0;
    logic scl_pull, sda_pull, start_sent, byte_done, ack_fail, bus_err;
    logic arb_lost, ev_any, busy, master, irq;
    logic scl_line, sda_line;

    assign scl_line = ~scl_pull;
    assign sda_line = ~(sda_pull | ext_sda_low);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    i2cm_tx_ctrl uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .cmd_irq_en(cmd_irq_en), .stat1_rd(stat1_rd),
        .stat2_rd(stat2_rd), .data_we(data_we), .data_in(data_in),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .start_sent(start_sent), .byte_done(byte_done),
        .ack_fail(ack_fail), .bus_err(bus_err), .arb_lost(arb_lost),
        .ev_any(ev_any), .busy(busy), .master(master), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic command(input bit s, input bit p, input bit ie);
        cmd_we = 1; cmd_start = s; cmd_stop = p; cmd_irq_en = ie;
        @(negedge clk);
        cmd_we = 0; cmd_start = 0; cmd_stop = 0;
    endtask

    task automatic handshake(input logic [7:0] b);
        stat1_rd = 1;
        @(negedge clk);
        stat1_rd = 0; data_we = 1; data_in = b;
        @(negedge clk);
        data_we = 0;
    endtask

    task automatic pulse_sr2;
        stat2_rd = 1;
        @(negedge clk);
        stat2_rd = 0;
    endtask

    task automatic scl_rise;
        logic p;
        int n;
        n = 0;
        p = scl_line;
        @(negedge clk);
        while (!(p == 1'b0 && scl_line == 1'b1) && n < 2000) begin
            p = scl_line;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic scl_fall;
        logic p;
        int n;
        n = 0;
        p = scl_line;
        @(negedge clk);
        while (!(p == 1'b1 && scl_line == 1'b0) && n < 2000) begin
            p = scl_line;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic send_bits(input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            scl_rise();
            got = {got[6:0], sda_line};
        end
    endtask

    task automatic ack_slot(input bit ack);
        scl_fall();
        ext_sda_low = ack;
        scl_rise();
        chk("R4 SDA released on ninth clock", sda_pull, 0);
    endtask

    task automatic wait_start_sent;
        int n;
        n = 0;
        while (start_sent !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_slave;
        int n;
        n = 0;
        while (master !== 1'b0 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        tick(4);
        rst = 0;
        tick(1);
        // R1 reset state
        chk("R1 master after reset", master, 0);
        chk("R1 flags after reset", {start_sent, byte_done, ack_fail, bus_err, arb_lost}, 0);
        chk("R1 busy/irq after reset", {busy, irq, ev_any}, 0);
        chk("R1 lines after reset", {scl_pull, sda_pull}, 0);

        // Session A: start, handshake order, all byte values, stop
        command(1, 0, 1);
        wait_start_sent();
        chk("R2 start_sent", start_sent, 1);
        chk("R2 busy and master", {busy, master}, 2'b11);
        chk("R2 SCL held after start", scl_pull, 1);
        chk("R12 irq with enable", {ev_any, irq}, 2'b11);
        data_we = 1; data_in = 8'hAA;
        @(negedge clk);
        data_we = 0;
        tick(6);
        chk("R3 write without status read ignored", {start_sent, scl_line}, 2'b10);
        for (int v = 0; v < 256; v++) begin
            handshake(v[7:0]);
            if (v == 255) command(0, 1, 1);
            send_bits(8, got);
            chk("R4 byte on SDA", got, v);
            ack_slot(1);
            scl_fall();
            ext_sda_low = 0;
            if (v < 255) begin
                chk("R5 byte_done after ack", byte_done, 1);
                chk("R5 SCL held after ack", scl_pull, 1);
                chk("R12 irq on byte_done", irq, 1);
            end
        end
        wait_slave();
        chk("R6 slave after stop", master, 0);
        chk("R6 busy clear after stop", busy, 0);
        chk("R6 no byte_done on stop byte", byte_done, 0);
        chk("R6 lines released", {scl_pull, sda_pull}, 0);

        // Session B: acknowledge failure and its re-set
        command(1, 0, 0);
        wait_start_sent();
        handshake(8'h3C);
        send_bits(8, got);
        chk("R4 byte 3C", got, 8'h3C);
        scl_fall();
        scl_rise();
        @(negedge clk);
        chk("R7 ack_fail set", {ack_fail, ev_any}, 2'b11);
        chk("R12 irq masked", irq, 0);
        stat2_rd = 1;
        @(negedge clk);
        stat2_rd = 0;
        chk("R8 cleared by read", ack_fail, 0);
        @(negedge clk);
        chk("R8 set again in ninth pulse", ack_fail, 1);
        tick(6);
        chk("R7 lines released", {scl_pull, sda_pull}, 0);
        chk("R7 still master", {master, ack_fail}, 2'b11);
        pulse_sr2();
        tick(1);
        chk("R8 cleared after ninth pulse", ack_fail, 0);
        command(0, 1, 0);
        wait_slave();
        chk("R7 stop command ends", {master, busy}, 0);

        // Session C: misplaced conditions
        command(1, 0, 1);
        wait_start_sent();
        handshake(8'hFF);
        scl_rise();
        @(negedge clk);
        ext_sda_low = 1;
        scl_fall();
        ext_sda_low = 0;
        chk("R11 no bus_err on first pulse", bus_err, 0);
        chk("R11 busy cleared", {busy, master}, 2'b01);
        send_bits(7, got);
        ack_slot(1);
        scl_fall();
        ext_sda_low = 0;
        chk("R11 byte completes", {byte_done, bus_err}, 2'b10);
        chk("R11 remaining bits", got[6:0], 7'h7F);
        handshake(8'hFF);
        send_bits(3, got);
        @(negedge clk);
        ext_sda_low = 1;
        @(negedge clk);
        chk("R10 bus_err set", {bus_err, ev_any, irq}, 3'b111);
        chk("R10 lines released", {scl_pull, sda_pull}, 0);
        ext_sda_low = 0;
        tick(2);
        pulse_sr2();
        chk("R13 bus_err cleared", {bus_err, ev_any}, 0);
        command(0, 1, 1);
        wait_slave();
        chk("R10 stop ends session", master, 0);

        // Session D: arbitration loss
        command(1, 0, 1);
        wait_start_sent();
        ext_sda_low = 1;
        handshake(8'hC0);
        scl_rise();
        @(negedge clk);
        chk("R9 arb_lost set", {arb_lost, ev_any}, 2'b11);
        chk("R9 slave mode", master, 0);
        chk("R9 lines released", {scl_pull, sda_pull}, 0);
        ext_sda_low = 0;
        tick(2);
        pulse_sr2();
        chk("R13 arb_lost cleared", {arb_lost, ev_any, irq}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule